// File: doc/BRIEF.md
# I2C Serial Memory Slave Protocol Engine

This block is the bus-facing half of a 2048-byte serial memory. It samples the two I2C wires (SCL and SDA) with a fast system clock and finds START and STOP conditions. It decodes the slave address byte against three strap inputs and acknowledges the bytes it accepts. It drives SDA only through an open-drain pull-down enable. Received write bytes go to a separate page-write buffer as strobed address/data pairs, and a commit strobe marks the STOP that ends a write. Array bytes come in through a one-cycle synchronous read port. While the write engine reports busy, no address byte is acknowledged, so a master can poll until the write has finished.

The controller is a single state machine with nine states:
- `ST_IDLE` ignores the bus until a START.
- `ST_DEVSEL` shifts in the address byte.
- `ST_DEVACK` holds the acknowledge for a matched address.
- `ST_BADDR` and `ST_BADDR_ACK` take in and acknowledge the byte address.
- `ST_WDATA` and `ST_WDATA_ACK` take in and acknowledge write data.
- `ST_RDATA` shifts a byte out.
- `ST_RACK` samples the master's acknowledge.

The transitions are:
- A START goes to `ST_DEVSEL` from any state, and a STOP goes to `ST_IDLE` from any state.
- From `ST_DEVSEL`, the eighth falling SCL edge goes to `ST_DEVACK` on a match while not busy, and to `ST_IDLE` otherwise.
- From `ST_DEVACK`, the next falling edge goes to `ST_RDATA` if the R/W bit was 1, and to `ST_BADDR` if it was 0.
- `ST_BADDR` goes to `ST_BADDR_ACK`, which goes to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK` after each byte and comes back to `ST_WDATA` after the acknowledge.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- From `ST_RACK`, a master ACK goes back to `ST_RDATA` and a NoACK goes to `ST_IDLE`.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the block is idle: `sda_oe`, `wr_valid`, `wr_commit` and `rd_en` are all 0.
- R2: An address byte is accepted only when all four select bits match, each counted from the MSB of the byte:
  - bit 7 is 1;
  - bit 6 equals `strap[2]`;
  - bit 5 equals the inverse of `strap[1]`;
  - bit 4 equals `strap[0]`.
  On a mismatch the byte is not acknowledged and the block ignores the bus until the next START.
- R3: Bits are sampled on rising SCL. An acknowledge is SDA held low through the 9th SCL clock. It is given for a matched address byte, for the byte-address byte and for every write data byte.
- R4: While `busy_in` is 1 at the end of an address byte, that byte is not acknowledged.
- R5: Bits 3..1 of an accepted address byte become memory address bits 10..8. The byte after a write-direction address byte becomes address bits 7..0.
- R6: Each write data byte produces one `wr_valid` pulse carrying the current address and the byte. After each byte the low 4 address bits increment and wrap within the 16-byte page, and bits 10..4 stay unchanged.
- R7: `wr_commit` pulses once on a STOP if at least one write data byte arrived since the last START. A repeated START before the STOP cancels the commit.
- R8: An address byte with bit 0 (R/W) equal to 1 starts a read at the current address, with bits 10..8 taken from that address byte. Bits go out MSB first and change after falling SCL edges.
- R9: A master ACK (SDA low on the 9th clock) makes the block send the next byte. The address increments after each byte sent and wraps from 2047 to 0.
- R10: A master NoACK ends the read and releases SDA. The address is left pointing at the byte after the last one sent, and a later current-address read continues from there.
- R11: A write-direction address byte, then a byte address, then a repeated START and a read-direction address byte, reads from the byte address just loaded.
- R12: Bytes clocked in before any START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap | input | 3 | Device-select strap inputs |
| busy_in | input | 1 | Write engine busy flag |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 11 | Address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle strobe: start the array write |
| rd_en | output | 1 | Read strobe to the array |
| rd_addr | output | 11 | Array read address |
| rd_data | input | 8 | Array read data, valid the cycle after `rd_en` |

## Verification
A wrong state or bit count shows up at the very next acknowledge slot: SDA is either held low where it should be released or left high where it should be low. A wrong address register shows up in the first read strobe or write strobe that follows, because that strobe carries the stale address. A lost or extra commit shows up within a few clocks of the STOP. The bench models the memory contents and the expected strobe sequences behaviourally. It compares every strobe on the clock where it occurs, and it checks every bit sampled from SDA in the middle of the SCL high phase.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_DEVACK,
        ST_BADDR,
        ST_BADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } slv_state_t;

    // Select nibble: fixed 1, strap[2], inverted strap[1], strap[0]
    function automatic logic sel_match(input logic [3:0] sel, input logic [2:0] strap);
        return sel == {1'b1, strap[2], ~strap[1], strap[0]};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr[0] <= 1'b1;
            sda_sr[0] <= 1'b1;
        end else begin
            scl_sr[0] <= scl_in;
            sda_sr[0] <= sda_in;
        end
    end

    for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scl_sr[gi] <= 1'b1;
                sda_sr[gi] <= 1'b1;
            end else begin
                scl_sr[gi] <= scl_sr[gi-1];
                sda_sr[gi] <= sda_sr[gi-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_sr[STAGES-1];
            sda_d <= sda_sr[STAGES-1];
        end
    end

    assign scl_now   = scl_sr[STAGES-1];
    assign sda_s     = sda_sr[STAGES-1];
    assign scl_rise  = scl_now & ~scl_d;
    assign scl_fall  = ~scl_now & scl_d;
    assign bus_start = scl_now & scl_d & sda_d & ~sda_s;
    assign bus_stop  = scl_now & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
    parameter int ADDR_W = 11,
    parameter int HI_W   = 3,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hi,
    input  logic [HI_W-1:0]   hi_val,
    input  logic              load_lo,
    input  logic [ADDR_W-HI_W-1:0] lo_val,
    input  logic              step_page,
    input  logic              step_full,
    output logic [ADDR_W-1:0] addr
);
    localparam int LO_W = ADDR_W - HI_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else begin
            if (load_hi)
                addr[ADDR_W-1 -: HI_W] <= hi_val;
            if (load_lo)
                addr[LO_W-1:0] <= lo_val;
            if (step_page)
                addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
            if (step_full)
                addr <= addr + 1'b1;
        end
    end

    // R6: a page step never disturbs the page number
    assert_page_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step_page) |-> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

    // R9: a full step from the top address wraps to zero
    assert_full_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step_full) && $past(addr) == {ADDR_W{1'b1}}) |-> addr == '0);

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [2:0]        strap,
    input  logic              busy_in,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    localparam int HI_W   = ADDR_W - 8;
    localparam int CNT_W  = 4;
    localparam logic [CNT_W-1:0] BITS_IN  = CNT_W'(8);
    localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(7);

    slv_state_t state_q, state_d;

    logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [CNT_W-1:0]  cnt_q;
    logic [7:0]        rx_q;
    logic [7:0]        tx_q;
    logic              rw_q, mack_q, wrote_q, fetch_q, load_q;
    logic              byte_done, tx_last, dev_ok, receiving;
    logic              load_hi, load_lo, step_page, step_full;
    logic [ADDR_W-1:0] addr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_addr_ctr #(.ADDR_W(ADDR_W), .HI_W(HI_W), .PAGE_W(PAGE_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_hi   (load_hi),
        .hi_val    (rx_q[HI_W:1]),
        .load_lo   (load_lo),
        .lo_val    (rx_q),
        .step_page (step_page),
        .step_full (step_full),
        .addr      (addr)
    );

    // Decode of bus events against the current state
    assign receiving = (state_q == ST_DEVSEL) || (state_q == ST_BADDR) || (state_q == ST_WDATA);
    assign byte_done = receiving && scl_fall && (cnt_q == BITS_IN);
    assign tx_last   = (state_q == ST_RDATA) && scl_fall && (cnt_q == LAST_OUT);
    assign dev_ok    = sel_match(rx_q[7:4], strap) && !busy_in;

    always_comb begin
        load_hi   = !bus_start && !bus_stop && (state_q == ST_DEVSEL) && byte_done && dev_ok;
        load_lo   = !bus_start && !bus_stop && (state_q == ST_BADDR) && byte_done;
        step_page = !bus_start && !bus_stop && (state_q == ST_WDATA) && byte_done;
        step_full = !bus_start && !bus_stop && tx_last;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (bus_start) begin
            state_d = ST_DEVSEL;
        end else if (bus_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEVSEL:    if (byte_done) state_d = dev_ok ? ST_DEVACK : ST_IDLE;
                ST_DEVACK:    if (scl_fall)  state_d = rw_q ? ST_RDATA : ST_BADDR;
                ST_BADDR:     if (byte_done) state_d = ST_BADDR_ACK;
                ST_BADDR_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:     if (tx_last)   state_d = ST_RACK;
                ST_RACK:      if (scl_fall)  state_d = mack_q ? ST_RDATA : ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath: bit counter, shifters, strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            rx_q      <= '0;
            tx_q      <= 8'hFF;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            wrote_q   <= 1'b0;
            fetch_q   <= 1'b0;
            load_q    <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            fetch_q   <= load_hi && rx_q[0] || step_full;
            load_q    <= fetch_q;
            if (load_q)
                tx_q <= rd_data;
            if (bus_start) begin
                cnt_q   <= '0;
                wrote_q <= 1'b0;
            end else if (bus_stop) begin
                cnt_q     <= '0;
                wr_commit <= wrote_q;
                wrote_q   <= 1'b0;
            end else if (receiving) begin
                if (scl_rise) begin
                    rx_q  <= {rx_q[6:0], sda_s};
                    cnt_q <= cnt_q + 1'b1;
                end else if (byte_done) begin
                    cnt_q <= '0;
                    if (state_q == ST_DEVSEL)
                        rw_q <= rx_q[0];
                    if (state_q == ST_WDATA) begin
                        wr_valid <= 1'b1;
                        wr_addr  <= addr;
                        wr_data  <= rx_q;
                        wrote_q  <= 1'b1;
                    end
                end
            end else if (state_q == ST_RDATA && scl_fall) begin
                if (cnt_q == LAST_OUT) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    tx_q  <= {tx_q[6:0], 1'b1};
                end
            end else if (state_q == ST_RACK && scl_rise) begin
                mack_q <= ~sda_s;
            end
        end
    end

    assign rd_en   = fetch_q;
    assign rd_addr = addr;

    // Output process: open-drain enable
    always_comb begin
        unique case (state_q)
            ST_DEVACK, ST_BADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~tx_q[7];
            default:                               sda_oe = 1'b0;
        endcase
    end

    // R4: an acknowledged address byte never ends while busy is raised
    assert_no_ack_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEVACK && $past(state_q) == ST_DEVSEL) |-> !$past(busy_in));

    // R7: commit strobes only follow a STOP on the bus
    assert_commit_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(bus_stop));

    // R6: write strobes appear only as the data acknowledge begins
    assert_wr_in_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> state_q == ST_WDATA_ACK);

    // R8: array reads are issued only from an acknowledge slot
    assert_rd_in_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (state_q == ST_DEVACK || state_q == ST_RACK));

endmodule

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam logic [2:0] STRAP = 3'b011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        busy = 1'b0;
    logic        sda_oe, wr_valid, wr_commit, rd_en;
    logic [10:0] wr_addr, rd_addr;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data = 8'h00;
    logic        line;

    int checks = 0;
    int errors = 0;
    int commits = 0;
    int exp_wr[$];
    int exp_rd[$];

    assign line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_mem_slave u_i2c_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(line), .sda_oe(sda_oe),
        .strap(STRAP), .busy_in(busy), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_commit(wr_commit), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + (a >> 8) * 11 + 5) & 255);
    endfunction

    function automatic logic [7:0] devbyte(input logic [2:0] hi, input logic rw);
        return {1'b1, STRAP[2], ~STRAP[1], STRAP[0], hi, rw};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Behavioural array: registered read
    always @(posedge clk) if (rd_en) rd_data <= pat(int'(rd_addr));

    // Per-clock comparison of strobes against the expected queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                if (exp_wr.size() == 0) check(0, "R6 unexpected write strobe", int'({wr_addr, wr_data}), 0);
                else begin
                    int e;
                    e = exp_wr.pop_front();
                    check(int'({wr_addr, wr_data}) == e, "R6 write strobe addr/data", int'({wr_addr, wr_data}), e);
                end
            end
            if (rd_en) begin
                if (exp_rd.size() == 0) check(0, "R9 unexpected read strobe", int'(rd_addr), 0);
                else begin
                    int e;
                    e = exp_rd.pop_front();
                    check(int'(rd_addr) == e, "R9 read strobe address", int'(rd_addr), e);
                end
            end
            if (wr_commit) commits++;
        end
    end

    task automatic qw(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw(); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw();
        end
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
        acked = (line == 1'b0);
        qw(); scl_m = 1'b0; qw();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl_m = 1'b1; qw(); b[i] = line; qw(); scl_m = 1'b0; qw();
        end
        sda_m = mack ? 1'b0 : 1'b1; qw(); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    initial begin : main
        logic       ack;
        logic [7:0] d;
        int         c0;
        repeat (5) @(negedge clk);
        check(sda_oe == 0 && wr_valid == 0 && wr_commit == 0 && rd_en == 0,
              "R1 reset outputs", int'({sda_oe, wr_valid, wr_commit, rd_en}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sda_oe == 0, "R1 idle after reset", int'(sda_oe), 0);

        // R12: a matching byte clocked without START
        scl_m = 1'b0; qw();
        send_byte(devbyte(3'd0, 1'b0), ack);
        check(!ack, "R12 no ack before START", int'(ack), 0);
        bus_stop();

        // R2: A1 select bit not inverted
        bus_start();
        send_byte({1'b1, STRAP[2], STRAP[1], STRAP[0], 4'b0000}, ack);
        check(!ack, "R2 mismatch not acked", int'(ack), 0);
        send_byte(8'h12, ack);
        check(!ack, "R2 ignored after mismatch", int'(ack), 0);
        bus_stop();

        // R3/R5/R6/R7: page write crossing the page end
        bus_start();
        send_byte(devbyte(3'b101, 1'b0), ack);
        check(ack, "R3 address ack", int'(ack), 1);
        send_byte(8'hFE, ack);
        check(ack, "R3 byte address ack", int'(ack), 1);
        exp_wr.push_back('h5FE_A1); exp_wr.push_back('h5FF_B2); exp_wr.push_back('h5F0_C3);
        send_byte(8'hA1, ack); check(ack, "R3 data ack 1", int'(ack), 1);
        send_byte(8'hB2, ack); check(ack, "R3 data ack 2", int'(ack), 1);
        send_byte(8'hC3, ack); check(ack, "R6 data ack after page wrap", int'(ack), 1);
        bus_stop();
        check(commits == 1, "R7 commit on STOP", commits, 1);
        check(exp_wr.size() == 0, "R6 all write strobes seen", exp_wr.size(), 0);

        // R4: busy blocks the address acknowledge
        busy = 1'b1;
        bus_start();
        send_byte(devbyte(3'b101, 1'b0), ack);
        check(!ack, "R4 no ack while busy", int'(ack), 0);
        bus_stop();
        busy = 1'b0;
        check(commits == 1, "R4 no commit while busy", commits, 1);

        // R8: current-address read from 0x5F1
        exp_rd.push_back('h5F1); exp_rd.push_back('h5F2);
        bus_start();
        send_byte(devbyte(3'b101, 1'b1), ack);
        check(ack, "R8 read address ack", int'(ack), 1);
        recv_byte(1'b0, d);
        check(d == pat('h5F1), "R8 current-address byte", int'(d), int'(pat('h5F1)));
        bus_stop();

        // R11/R5/R9: random read at 0x7FE then wrap to 0
        exp_rd.push_back('h7FE); exp_rd.push_back('h7FF); exp_rd.push_back('h000); exp_rd.push_back('h001);
        bus_start();
        send_byte(devbyte(3'b111, 1'b0), ack); check(ack, "R11 dummy write ack", int'(ack), 1);
        send_byte(8'hFE, ack);                 check(ack, "R5 byte address ack", int'(ack), 1);
        bus_start();
        send_byte(devbyte(3'b111, 1'b1), ack); check(ack, "R11 read ack", int'(ack), 1);
        recv_byte(1'b1, d); check(d == pat('h7FE), "R11 random read byte", int'(d), int'(pat('h7FE)));
        recv_byte(1'b1, d); check(d == pat('h7FF), "R9 sequential byte", int'(d), int'(pat('h7FF)));
        recv_byte(1'b0, d); check(d == pat('h000), "R9 wrap to 0", int'(d), int'(pat('h000)));
        bus_stop();
        check(sda_oe == 0, "R10 SDA released after NoACK", int'(sda_oe), 0);

        // R10: continue from 0x001 with new bits 10..8
        exp_rd.push_back('h201); exp_rd.push_back('h202);
        bus_start();
        send_byte(devbyte(3'b010, 1'b1), ack); check(ack, "R10 read ack", int'(ack), 1);
        recv_byte(1'b0, d);
        check(d == pat('h201), "R10 continued address", int'(d), int'(pat('h201)));
        bus_stop();

        // R7: repeated START cancels the commit
        c0 = commits;
        exp_wr.push_back('h010_55);
        exp_rd.push_back('h011); exp_rd.push_back('h012);
        bus_start();
        send_byte(devbyte(3'b000, 1'b0), ack); check(ack, "R3 address ack 2", int'(ack), 1);
        send_byte(8'h10, ack);                 check(ack, "R3 byte address ack 2", int'(ack), 1);
        send_byte(8'h55, ack);                 check(ack, "R3 data ack 3", int'(ack), 1);
        bus_start();
        send_byte(devbyte(3'b000, 1'b1), ack); check(ack, "R8 read ack 2", int'(ack), 1);
        recv_byte(1'b0, d);
        check(d == pat('h011), "R8 read after write bytes", int'(d), int'(pat('h011)));
        bus_stop();
        check(commits == c0, "R7 no commit after repeated START", commits, c0);

        qw(2);
        check(exp_wr.size() == 0, "R6 write queue empty", exp_wr.size(), 0);
        check(exp_rd.size() == 0, "R9 read queue empty", exp_rd.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule